// File: doc/BRIEF.md
# Machine-Mode Trigger Enable Control

This block owns a small trigger-control register that holds two live bits: a machine-mode trigger enable and a saved copy of that enable. When the hart traps into machine mode, the current enable is saved and the live enable is cleared. This keeps a breakpoint trigger from firing again inside its own handler. On a return from machine mode the saved copy is restored. Software can also read and write both bits through a CSR port at address 0x7A5.

The block also qualifies raw trigger matches. A match counts only when three things hold: the privilege mode matches, the extra-condition check passes, and the hart is allowed to trigger at the privilege being evaluated. A hart below machine mode is always allowed. In machine mode, a trigger is allowed when its action field is nonzero (it does something other than raise a breakpoint exception) or when the enable bit is set. The privilege used for this test is either the current privilege or the privilege in force before the last trap, chosen by a select input. When the trigger module is configured out, the register reads zero and cannot be changed.

Top module: `trig_mte_ctl`

## Requirements
- R1: After reset, the enable (bit 3) and the saved enable (bit 7) are both 0, and a read at address 0x7A5 returns 0.
- R2: A write at address 0x7A5 stores wdata bit 3 as the enable and wdata bit 7 as the saved enable. Every other read bit is 0. A read at any other address returns 0, and a write at any other address changes nothing. csr_hit_o is 1 exactly when csr_addr_i equals 0x7A5.
- R3: On a cycle with trap_m_i high, the next state has the saved enable equal to the old enable, and the enable equal to 0.
- R4: On a cycle with mret_i high and trap_m_i low, both bits take the old saved-enable value on the next edge.
- R5: trap_m_i or mret_i overrides a CSR write in the same cycle, so the write is dropped. trap_m_i overrides mret_i when both are high.
- R6: match_o is combinational. It is 1 only when mode_match_i and extra_match_i are both 1 and at least one of these holds: the evaluated privilege is below 3 (3 means machine mode), action_i is nonzero (0 means breakpoint exception), or the enable is 1.
- R7: The evaluated privilege is priv_prev_i when use_prev_i is 1, and priv_cur_i when use_prev_i is 0.
- R8: With HAS_TRIG = 0, reads return 0, writes and trap or return events have no effect, and match_o behaves as if the enable were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (0 when the address misses) |
| csr_hit_o | output | 1 | Address decodes to this register |
| trap_m_i | input | 1 | Trap taken into machine mode |
| mret_i | input | 1 | Return from machine mode |
| priv_cur_i | input | 2 | Current privilege |
| priv_prev_i | input | 2 | Privilege before the last trap |
| use_prev_i | input | 1 | Evaluate the match against priv_prev_i |
| action_i | input | 4 | Action field of the matched trigger |
| mode_match_i | input | 1 | Raw mode-match result |
| extra_match_i | input | 1 | Raw extra-condition result |
| match_o | output | 1 | Qualified trigger match |

## Verification
The bench targets several corner cases, each of which exposes a specific kind of bug. A trap followed by a return should restore the enable; a design with the push or pop swapped would leave it lost or stuck. When a CSR write lands in the same cycle as a trap or return, the event must win; a design with the wrong priority would keep the written value. When a trap and a return coincide, the trap must win; a wrong design would restore the enable. The bench also checks that a machine-mode trigger with action 0 and the enable clear is suppressed, while a nonzero action passes. A qualifier that picks the wrong privilege would give the wrong answer whenever use_prev_i selects a different mode. Finally, a second instance with the trigger module configured out must stay at zero through all of the same stimulus.

// File: rtl/trig_ctl_pkg.sv
package trig_ctl_pkg;
  localparam int unsigned PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;
  localparam int unsigned CSR_AW = 12;
endpackage

// File: rtl/trig_csr_dec.sv
module trig_csr_dec #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned AW       = 12,
  parameter logic [AW-1:0] ADDR   = 12'h7A5,
  parameter int unsigned MTE_BIT  = 3,
  parameter int unsigned MPTE_BIT = 7
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            mte_i,
  input  logic            mpte_i,
  output logic            hit_o,
  output logic            wr_en_o,
  output logic            wr_mte_o,
  output logic            wr_mpte_o,
  output logic [XLEN-1:0] rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign hit_o     = (addr_i == ADDR);
  assign wr_en_o   = hit_o & we_i;
  assign wr_mte_o  = wdata_i[MTE_BIT];
  assign wr_mpte_o = wdata_i[MPTE_BIT];

  always_comb begin
    rdata_o = '0;
    if (hit_o) begin
      rdata_o[MTE_BIT]  = mte_i;
      rdata_o[MPTE_BIT] = mpte_i;
    end
  end
endmodule

// File: rtl/trig_mte_state.sv
module trig_mte_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trap_m_i,
  input  logic mret_i,
  input  logic wr_en_i,
  input  logic wr_mte_i,
  input  logic wr_mpte_i,
  output logic mte_o,
  output logic mpte_o
);
  logic mte_q, mpte_q, mte_d, mpte_d;

  // events outrank software writes; trap outranks return
  always_comb begin
    mte_d  = mte_q;
    mpte_d = mpte_q;
    if (trap_m_i) begin
      mpte_d = mte_q;
      mte_d  = 1'b0;
    end else if (mret_i) begin
      mte_d  = mpte_q;
    end else if (wr_en_i) begin
      mte_d  = wr_mte_i;
      mpte_d = wr_mpte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mte_q  <= 1'b0;
      mpte_q <= 1'b0;
    end else begin
      mte_q  <= mte_d;
      mpte_q <= mpte_d;
    end
  end

  assign mte_o  = mte_q;
  assign mpte_o = mpte_q;
endmodule

// File: rtl/trig_match_qual.sv
module trig_match_qual
  import trig_ctl_pkg::*;
#(
  parameter int unsigned ACT_W = 4
) (
  input  logic [PRIV_W-1:0] priv_cur_i,
  input  logic [PRIV_W-1:0] priv_prev_i,
  input  logic              use_prev_i,
  input  logic [ACT_W-1:0]  action_i,
  input  logic              mode_match_i,
  input  logic              extra_match_i,
  input  logic              mte_i,
  output logic              match_o
);
  logic [PRIV_W-1:0] priv_sel;
  logic              below_m, m_ok;

  assign priv_sel = use_prev_i ? priv_prev_i : priv_cur_i;
  assign below_m  = (priv_sel < PRIV_M);
  assign m_ok     = (|action_i) | mte_i;
  assign match_o  = mode_match_i & extra_match_i & (below_m | m_ok);
endmodule

// File: rtl/trig_mte_ctl.sv
module trig_mte_ctl
  import trig_ctl_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ACT_W    = 4,
  parameter logic [11:0] CSR_ADDR = 12'h7A5,
  parameter int unsigned MTE_BIT  = 3,
  parameter int unsigned MPTE_BIT = 7,
  parameter bit          HAS_TRIG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       csr_addr_i,
  input  logic              csr_we_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_hit_o,
  input  logic              trap_m_i,
  input  logic              mret_i,
  input  logic [1:0]        priv_cur_i,
  input  logic [1:0]        priv_prev_i,
  input  logic              use_prev_i,
  input  logic [ACT_W-1:0]  action_i,
  input  logic              mode_match_i,
  input  logic              extra_match_i,
  output logic              match_o
);
  logic wr_en, wr_mte, wr_mpte;
  logic mte_q, mpte_q;

  trig_csr_dec #(
    .XLEN(XLEN), .AW(CSR_AW), .ADDR(CSR_ADDR),
    .MTE_BIT(MTE_BIT), .MPTE_BIT(MPTE_BIT)
  ) u_dec (
    .addr_i   (csr_addr_i),
    .we_i     (csr_we_i),
    .wdata_i  (csr_wdata_i),
    .mte_i    (mte_q),
    .mpte_i   (mpte_q),
    .hit_o    (csr_hit_o),
    .wr_en_o  (wr_en),
    .wr_mte_o (wr_mte),
    .wr_mpte_o(wr_mpte),
    .rdata_o  (csr_rdata_o)
  );

  if (HAS_TRIG) begin : g_state
    trig_mte_state u_state (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trap_m_i (trap_m_i),
      .mret_i   (mret_i),
      .wr_en_i  (wr_en),
      .wr_mte_i (wr_mte),
      .wr_mpte_i(wr_mpte),
      .mte_o    (mte_q),
      .mpte_o   (mpte_q)
    );
  end else begin : g_tied
    logic unused_state;
    assign unused_state = ^{clk_i, rst_ni, trap_m_i, mret_i, wr_en, wr_mte, wr_mpte};
    assign mte_q  = 1'b0;
    assign mpte_q = 1'b0;
  end

  trig_match_qual #(.ACT_W(ACT_W)) u_qual (
    .priv_cur_i   (priv_cur_i),
    .priv_prev_i  (priv_prev_i),
    .use_prev_i   (use_prev_i),
    .action_i     (action_i),
    .mode_match_i (mode_match_i),
    .extra_match_i(extra_match_i),
    .mte_i        (mte_q),
    .match_o      (match_o)
  );
endmodule

// File: rtl/trig_mte_ctl_chk.sv
module trig_mte_ctl_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ACT_W    = 4,
  parameter int unsigned MTE_BIT  = 3,
  parameter int unsigned MPTE_BIT = 7,
  parameter bit          HAS_TRIG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csr_hit_o,
  input logic              csr_we_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              trap_m_i,
  input logic              mret_i,
  input logic [1:0]        priv_cur_i,
  input logic [1:0]        priv_prev_i,
  input logic              use_prev_i,
  input logic [ACT_W-1:0]  action_i,
  input logic              mode_match_i,
  input logic              extra_match_i,
  input logic              match_o,
  input logic              mte_q,
  input logic              mpte_q
);
  logic [XLEN-1:0] live_mask;
  logic [1:0]      eval_priv;
  always_comb begin
    live_mask = '0;
    live_mask[MTE_BIT]  = 1'b1;
    live_mask[MPTE_BIT] = 1'b1;
    eval_priv = use_prev_i ? priv_prev_i : priv_cur_i;
  end

  p_rdata_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rdata_o & ~live_mask) == '0);

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_TRIG && csr_hit_o && csr_we_i && !trap_m_i && !mret_i)
    |=> (mte_q == $past(csr_wdata_i[MTE_BIT]) && mpte_q == $past(csr_wdata_i[MPTE_BIT])));

  p_trap_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_m_i |=> (!mte_q && mpte_q == $past(mte_q)));

  p_mret_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_m_i) |=> (mte_q == $past(mpte_q) && mpte_q == $past(mpte_q)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_m_i && !mret_i && !(csr_hit_o && csr_we_i)) |=> ($stable(mte_q) && $stable(mpte_q)));

  p_raw_needed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (mode_match_i && extra_match_i));

  p_m_suppress_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_priv == 2'd3 && action_i == '0 && !mte_q) |-> !match_o);

  p_absent_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_TRIG |-> (csr_rdata_o == '0));
endmodule

bind trig_mte_ctl trig_mte_ctl_chk #(
  .XLEN(XLEN), .ACT_W(ACT_W), .MTE_BIT(MTE_BIT), .MPTE_BIT(MPTE_BIT), .HAS_TRIG(HAS_TRIG)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_hit_o    (csr_hit_o),
  .csr_we_i     (csr_we_i),
  .csr_wdata_i  (csr_wdata_i),
  .csr_rdata_o  (csr_rdata_o),
  .trap_m_i     (trap_m_i),
  .mret_i       (mret_i),
  .priv_cur_i   (priv_cur_i),
  .priv_prev_i  (priv_prev_i),
  .use_prev_i   (use_prev_i),
  .action_i     (action_i),
  .mode_match_i (mode_match_i),
  .extra_match_i(extra_match_i),
  .match_o      (match_o),
  .mte_q        (mte_q),
  .mpte_q       (mpte_q)
);

// File: tb/trig_mte_ctl_bench.sv
module trig_mte_ctl_bench;
  localparam int XLEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [11:0]     csr_addr_i = '0;
  logic            csr_we_i = 1'b0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic            trap_m_i = 1'b0, mret_i = 1'b0;
  logic [1:0]      priv_cur_i = '0, priv_prev_i = '0;
  logic            use_prev_i = 1'b0;
  logic [3:0]      action_i = '0;
  logic            mode_match_i = 1'b0, extra_match_i = 1'b0;
  logic [XLEN-1:0] rdata, rdata_n;
  logic            hit, hit_n, match, match_n;

  always #4 clk_i = ~clk_i;

  trig_mte_ctl u_trig_mte_ctl (
    .clk_i, .rst_ni, .csr_addr_i, .csr_we_i, .csr_wdata_i,
    .csr_rdata_o(rdata), .csr_hit_o(hit), .trap_m_i, .mret_i,
    .priv_cur_i, .priv_prev_i, .use_prev_i, .action_i,
    .mode_match_i, .extra_match_i, .match_o(match)
  );

  trig_mte_ctl #(.HAS_TRIG(1'b0)) u_notrig (
    .clk_i, .rst_ni, .csr_addr_i, .csr_we_i, .csr_wdata_i,
    .csr_rdata_o(rdata_n), .csr_hit_o(hit_n), .trap_m_i, .mret_i,
    .priv_cur_i, .priv_prev_i, .use_prev_i, .action_i,
    .mode_match_i, .extra_match_i, .match_o(match_n)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit m_mte = 1'b0, m_mpte = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_match(input bit en);
    logic [1:0] p;
    p = use_prev_i ? priv_prev_i : priv_cur_i;
    return mode_match_i && extra_match_i && (p < 2'd3 || action_i != 0 || en);
  endfunction

  // compare combinational outputs now, then advance the model across the edge
  task automatic cyc(input string tag);
    longint er;
    bit     eh;
    #2;
    eh = (csr_addr_i == 12'h7A5);
    er = eh ? ((longint'(m_mte) << 3) | (longint'(m_mpte) << 7)) : 0;
    chk(tag, "hit", hit, eh);
    chk(tag, "rdata", rdata, er);
    chk(tag, "match", match, exp_match(m_mte));
    chk("R8", "rdata_absent", rdata_n, 0);
    chk("R8", "match_absent", match_n, exp_match(1'b0));
    @(posedge clk_i);
    if (trap_m_i) begin
      m_mpte = m_mte; m_mte = 1'b0;
    end else if (mret_i) begin
      m_mte = m_mpte;
    end else if (eh && csr_we_i) begin
      m_mte = csr_wdata_i[3]; m_mpte = csr_wdata_i[7];
    end
    @(negedge clk_i);
    trap_m_i = 1'b0; mret_i = 1'b0; csr_we_i = 1'b0;
  endtask

  task automatic wr(input logic [XLEN-1:0] d, input string tag);
    csr_addr_i = 12'h7A5; csr_we_i = 1'b1; csr_wdata_i = d;
    cyc(tag);
  endtask

  task automatic rd(input logic [XLEN-1:0] exp, input string tag);
    csr_addr_i = 12'h7A5;
    #2;
    chk(tag, "readback", rdata, exp);
    cyc(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    csr_addr_i = 12'h7A5;
    #1;
    chk("R1", "reset_rdata", rdata, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(32'h0, "R1");

    // R2: only bits 3 and 7 stick
    wr(32'hFFFF_FFFF, "R2");
    rd(32'h88, "R2");
    wr(32'h0000_0008, "R2");
    rd(32'h08, "R2");
    csr_addr_i = 12'h7A4; csr_we_i = 1'b1; csr_wdata_i = 32'h80;
    cyc("R2");
    rd(32'h08, "R2");

    // R3 then R4: push and pop
    trap_m_i = 1'b1; cyc("R3");
    rd(32'h80, "R3");
    trap_m_i = 1'b1; cyc("R3");
    rd(32'h00, "R3");
    wr(32'h80, "R4");
    mret_i = 1'b1; cyc("R4");
    rd(32'h88, "R4");
    wr(32'h08, "R4");
    mret_i = 1'b1; cyc("R4");
    rd(32'h00, "R4");

    // R5: priorities
    wr(32'h08, "R5");
    csr_we_i = 1'b1; csr_wdata_i = 32'h08; trap_m_i = 1'b1; cyc("R5");
    rd(32'h80, "R5");
    csr_we_i = 1'b1; csr_wdata_i = 32'h00; mret_i = 1'b1; cyc("R5");
    rd(32'h88, "R5");
    trap_m_i = 1'b1; mret_i = 1'b1; cyc("R5");
    rd(32'h80, "R5");

    // R6/R7: qualification, enable currently 0
    mode_match_i = 1'b1; extra_match_i = 1'b1;
    priv_cur_i = 2'd3; priv_prev_i = 2'd0; use_prev_i = 1'b0; action_i = 4'd0;
    #2; chk("R6", "m_bkpt_suppressed", match, 0);
    action_i = 4'd1;
    #1; chk("R6", "m_action_passes", match, 1);
    action_i = 4'd0; use_prev_i = 1'b1;
    #1; chk("R7", "prev_user_passes", match, 1);
    priv_cur_i = 2'd1; priv_prev_i = 2'd3;
    #1; chk("R7", "prev_machine_suppressed", match, 0);
    use_prev_i = 1'b0;
    #1; chk("R7", "cur_super_passes", match, 1);
    extra_match_i = 1'b0;
    #1; chk("R6", "extra_required", match, 0);
    extra_match_i = 1'b1; priv_cur_i = 2'd3;
    wr(32'h08, "R6");
    #2; chk("R6", "m_enabled_passes", match, 1);
    chk("R8", "absent_suppressed", match_n, 0);
    cyc("R6");

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      csr_addr_i    = ($urandom_range(0, 1) == 1) ? 12'h7A5 : 12'($urandom);
      csr_we_i      = ($urandom_range(0, 2) == 0);
      csr_wdata_i   = $urandom;
      trap_m_i      = ($urandom_range(0, 5) == 0);
      mret_i        = ($urandom_range(0, 5) == 0);
      priv_cur_i    = 2'($urandom);
      priv_prev_i   = 2'($urandom);
      use_prev_i    = 1'($urandom);
      action_i      = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'd0;
      mode_match_i  = ($urandom_range(0, 3) != 0);
      extra_match_i = ($urandom_range(0, 3) != 0);
      cyc("R6");
    end
    summary();
  end
endmodule